// File: doc/BRIEF.md
# Double-Buffered Display Register File with Per-Port Commit

This block holds the configuration registers of a display controller that drives several output ports and several image windows. The configuration registers that affect what is on screen have two copies. Software writes a staging copy. The hardware-facing active copy takes the staged value only at a commit point, so a frame never starts with half of a new configuration applied. Readback over the register bus always returns the active copy. The remaining registers take effect as soon as they are written.

Software requests a commit by writing the commit register. That write arms one or more ports. On the next rising vsync of an armed port, three things happen. The port's own registers commit. Every window currently routed to that port commits. The layer-select register commits if that port is its selected commit source. A control bit can make the port-level registers follow their staging copies without a vsync. Window registers never follow it, so a window routed to a port whose vsync never toggles keeps its old active values.

Each port runs a two-state commit machine. In PS_IDLE the port has no pending request. The ARM transition, an accepted commit request, moves it to PS_ARMED. In PS_ARMED, a rising vsync edge fires COMMIT and returns the machine to PS_IDLE. If a new request arrives in that same cycle, RE-ARM applies instead: the commit still fires and the machine stays in PS_ARMED.

Top module: `shreg_file`

## Requirements
- R1: A write to a staged register (port control, layer select, window control, base, stride, size) changes neither its output nor its readback value until a commit loads it.
- R2: A write to the commit register (word address 0) arms port p only if bit 15 (global enable), request bit p and mask bit p+16 are all set. A write that lacks the enable bit or the matching mask bit arms nothing.
- R3: A single commit write can arm several ports. Each armed port then commits independently on its own vsync.
- R4: Commit register readback returns the per-port pending flags in bits [NPORTS-1:0]. A port's flag is set by an accepted request. It clears on that port's next rising vsync, and the active copies loaded at that edge are visible from the following cycle.
- R5: While bit 28 of the system control register (address 1) is set, each port control active copy loads its staging copy on every clock. Window registers are not affected by this bit.
- R6: The routing register (address 3) assigns window w to a port through bits [2w+1:2w]. A window commits only on the vsync of its routed port, so a window routed to a port whose vsync never rises never commits.
- R7: Bits 31:30 of the overlay control register (address 2) select the port whose commit loads the layer-select register (address 4). Commits of other ports leave it unchanged.
- R8: The system control, overlay control, routing and per-port auxiliary (addresses 32+p) registers take effect on write and read back the written value (routing: low 2*NWIN bits) on the next cycle.
- R9: Two staging writes to the same register before a commit result in only the last value being applied.
- R10: After reset, staging and active copies hold their defaults: window stride 0x780, window size 0x0437077F, layer select 0x76543210, and all other registers 0. No port is pending.
- R11: A rising vsync on a port that has no pending request changes no active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address for write and read |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| vsync | input | NPORTS | Per-port vertical sync, synchronous to clk |
| pending_o | output | NPORTS | Per-port pending commit flags |
| port_ctrl_o | output | NPORTS*DW | Active port control copies |
| layer_sel_o | output | DW | Active layer-select value |
| route_o | output | 2*NWIN | Window-to-port routing |
| win_ctrl_o | output | NWIN*DW | Active window control copies |
| win_base_o | output | NWIN*DW | Active window base addresses |
| win_stride_o | output | NWIN*DW | Active window strides |
| win_size_o | output | NWIN*DW | Active window sizes |

## Verification
The stimulus covers several kinds of commit write. One lacks the enable bit, one lacks the mask bit, one requests a single port and one requests two ports at once. Comparing these shows that the accept check and the per-port arming are separate. Vsync pulses are issued on armed ports, on unarmed ports and never on one routed port. This shows the difference between committing on the routed port's edge, on any edge, or on no edge. Runs with the immediate-latch bit on and off show that the bit covers port-level registers and leaves windows alone. The layer-select source is tested by moving it between ports.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic {
        PS_IDLE,
        PS_ARMED
    } port_state_e;

    localparam int A_COMMIT     = 0;
    localparam int A_SYSCTL     = 1;
    localparam int A_OVLCTL     = 2;
    localparam int A_ROUTE      = 3;
    localparam int A_LAYERSEL   = 4;
    localparam int A_PCTRL_BASE = 16;
    localparam int A_PAUX_BASE  = 32;
    localparam int A_WIN_BASE   = 64;
    localparam int WIN_FIELDS   = 4;

    localparam int CMT_EN_BIT   = 15;
    localparam int CMT_MASK_OFS = 16;
    localparam int IMM_BIT      = 28;

endpackage

// File: rtl/shadow_word.sv
module shadow_word #(
    parameter int          DW  = 32,
    parameter logic [DW-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_we,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output logic [DW-1:0] stage_q,
    output logic [DW-1:0] act_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= RST;
            act_q   <= RST;
        end else begin
            if (stage_we) stage_q <= wdata;
            if (load)     act_q   <= stage_q;
        end
    end

    // R1: active copy only moves on a load
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // R9: a load applies the latest staged value
    p_load_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> act_q == $past(stage_q));

endmodule

// File: rtl/port_commit_fsm.sv
module port_commit_fsm
    import shreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic vsync,
    output logic pending_o,
    output logic commit_o
);

    port_state_e state_q, state_d;
    logic        vs_q;
    logic        vs_rise;

    assign vs_rise = vsync & ~vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            vs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_q    <= vsync;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (req) state_d = PS_ARMED;
            PS_ARMED: if (req) state_d = PS_ARMED;
                      else if (vs_rise) state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        pending_o = 1'b0;
        commit_o  = 1'b0;
        unique case (state_q)
            PS_IDLE:  ;
            PS_ARMED: begin
                pending_o = 1'b1;
                commit_o  = vs_rise;
            end
            default:  ;
        endcase
    end

    // R4: an accepted request always leaves the port pending
    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pending_o);

    // R4: a commit without a new request clears pending
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !req) |=> !pending_o);

    // R11: no commit unless previously armed
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !req) |=> !commit_o);

endmodule

// File: rtl/shreg_file.sv
module shreg_file
    import shreg_pkg::*;
#(
    parameter int            NPORTS        = 4,
    parameter int            NWIN          = 4,
    parameter int            DW            = 32,
    parameter int            AW            = 8,
    parameter logic [DW-1:0] WIN_STRIDE_RST = 32'h0000_0780,
    parameter logic [DW-1:0] WIN_SIZE_RST   = 32'h0437_077F,
    parameter logic [DW-1:0] LAYER_RST      = 32'h7654_3210
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [NPORTS-1:0]     vsync,
    output logic [NPORTS-1:0]     pending_o,
    output logic [NPORTS*DW-1:0]  port_ctrl_o,
    output logic [DW-1:0]         layer_sel_o,
    output logic [2*NWIN-1:0]     route_o,
    output logic [NWIN*DW-1:0]    win_ctrl_o,
    output logic [NWIN*DW-1:0]    win_base_o,
    output logic [NWIN*DW-1:0]    win_stride_o,
    output logic [NWIN*DW-1:0]    win_size_o
);

    localparam int PSEL_W = 2;
    localparam int RT_W   = PSEL_W * NWIN;

    logic [DW-1:0]     sys_q, ovl_q;
    logic [RT_W-1:0]   route_q;
    logic [DW-1:0]     aux_q [NPORTS];
    logic [NPORTS-1:0] req, commit;
    logic              cmt_wr, imm;
    logic [DW-1:0]     pc_act [NPORTS];
    logic [DW-1:0]     win_act [NWIN][WIN_FIELDS];
    logic [DW-1:0]     ls_act;

    assign cmt_wr = wr_en && (addr == AW'(A_COMMIT)) && wdata[CMT_EN_BIT];
    assign imm    = sys_q[IMM_BIT];

    // plain registers: immediate effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_q   <= '0;
            ovl_q   <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            if (addr == AW'(A_SYSCTL)) sys_q   <= wdata;
            if (addr == AW'(A_OVLCTL)) ovl_q   <= wdata;
            if (addr == AW'(A_ROUTE))  route_q <= wdata[RT_W-1:0];
        end
    end

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            logic [DW-1:0] pc_stage;
            assign req[p] = cmt_wr && wdata[p] && wdata[p + CMT_MASK_OFS];

            port_commit_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (req[p]),
                .vsync    (vsync[p]),
                .pending_o(pending_o[p]),
                .commit_o (commit[p])
            );

            shadow_word #(.DW(DW), .RST('0)) u_pc (
                .clk     (clk),
                .rst_n   (rst_n),
                .stage_we(wr_en && (addr == AW'(A_PCTRL_BASE + p))),
                .wdata   (wdata),
                .load    (commit[p] || imm),
                .stage_q (pc_stage),
                .act_q   (pc_act[p])
            );

            always_ff @(posedge clk) begin
                if (!rst_n) aux_q[p] <= '0;
                else if (wr_en && (addr == AW'(A_PAUX_BASE + p))) aux_q[p] <= wdata;
            end

            assign port_ctrl_o[p*DW +: DW] = pc_act[p];
        end

        for (genvar w = 0; w < NWIN; w++) begin : g_win
            logic [PSEL_W-1:0] wport;
            logic              wload;
            assign wport = route_q[w*PSEL_W +: PSEL_W];
            assign wload = commit[wport];

            for (genvar f = 0; f < WIN_FIELDS; f++) begin : g_fld
                localparam logic [DW-1:0] FRST = (f == 2) ? WIN_STRIDE_RST :
                                                 (f == 3) ? WIN_SIZE_RST : '0;
                logic [DW-1:0] stage_unused;
                shadow_word #(.DW(DW), .RST(FRST)) u_w (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .stage_we(wr_en && (addr == AW'(A_WIN_BASE + w*WIN_FIELDS + f))),
                    .wdata   (wdata),
                    .load    (wload),
                    .stage_q (stage_unused),
                    .act_q   (win_act[w][f])
                );
            end

            assign win_ctrl_o  [w*DW +: DW] = win_act[w][0];
            assign win_base_o  [w*DW +: DW] = win_act[w][1];
            assign win_stride_o[w*DW +: DW] = win_act[w][2];
            assign win_size_o  [w*DW +: DW] = win_act[w][3];
        end
    endgenerate

    logic [DW-1:0] ls_stage;
    shadow_word #(.DW(DW), .RST(LAYER_RST)) u_ls (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_we(wr_en && (addr == AW'(A_LAYERSEL))),
        .wdata   (wdata),
        .load    (commit[ovl_q[31 -: PSEL_W]]),
        .stage_q (ls_stage),
        .act_q   (ls_act)
    );

    assign layer_sel_o = ls_act;
    assign route_o     = route_q;

    // readback mux: active copies only
    always_comb begin
        rdata = '0;
        if (addr == AW'(A_COMMIT))   rdata = DW'(pending_o);
        if (addr == AW'(A_SYSCTL))   rdata = sys_q;
        if (addr == AW'(A_OVLCTL))   rdata = ovl_q;
        if (addr == AW'(A_ROUTE))    rdata = DW'(route_q);
        if (addr == AW'(A_LAYERSEL)) rdata = ls_act;
        for (int p = 0; p < NPORTS; p++) begin
            if (addr == AW'(A_PCTRL_BASE + p)) rdata = pc_act[p];
            if (addr == AW'(A_PAUX_BASE + p))  rdata = aux_q[p];
        end
        for (int w = 0; w < NWIN; w++)
            for (int f = 0; f < WIN_FIELDS; f++)
                if (addr == AW'(A_WIN_BASE + w*WIN_FIELDS + f)) rdata = win_act[w][f];
    end

    // R5: without any port commit, window actives never move (immediate latch included)
    p_win_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit == '0) |=> $stable({win_ctrl_o, win_base_o, win_stride_o, win_size_o}));

    // R2: a commit write lacking the enable bit arms no new port
    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_COMMIT) && !wdata[CMT_EN_BIT])
        |=> ((pending_o & ~$past(pending_o)) == '0));

    // R7: layer select moves only on a commit
    p_ls_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit == '0) |=> $stable(layer_sel_o));

endmodule

// File: tb/shreg_file_tb.sv
module shreg_file_tb;

    localparam int NP = 4, NW = 4, DW = 32, AW = 8;

    logic             clk = 0, rst_n = 0, wr_en = 0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic [NP-1:0]    vsync = '0;
    logic [NP-1:0]    pending_o;
    logic [NP*DW-1:0] port_ctrl_o;
    logic [DW-1:0]    layer_sel_o;
    logic [2*NW-1:0]  route_o;
    logic [NW*DW-1:0] win_ctrl_o, win_base_o, win_stride_o, win_size_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shreg_file u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .vsync(vsync), .pending_o(pending_o),
        .port_ctrl_o(port_ctrl_o), .layer_sel_o(layer_sel_o), .route_o(route_o),
        .win_ctrl_o(win_ctrl_o), .win_base_o(win_base_o),
        .win_stride_o(win_stride_o), .win_size_o(win_size_o)
    );

    // ---------------- behavioural reference ----------------
    logic [DW-1:0] m_pcs [NP], m_pca [NP], m_aux [NP];
    logic [DW-1:0] m_ws [NW][4], m_wa [NW][4];
    logic [DW-1:0] m_lss, m_lsa, m_sys, m_ovl;
    logic [7:0]    m_route;
    logic [NP-1:0] m_pend, m_vsp;

    function automatic logic [DW-1:0] wdef(int f);
        if (f == 2) return 32'h0000_0780;
        if (f == 3) return 32'h0437_077F;
        return '0;
    endfunction

    task automatic m_reset();
        for (int p = 0; p < NP; p++) begin m_pcs[p] = '0; m_pca[p] = '0; m_aux[p] = '0; end
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) begin m_ws[w][f] = wdef(f); m_wa[w][f] = wdef(f); end
        m_lss = 32'h7654_3210; m_lsa = 32'h7654_3210;
        m_sys = '0; m_ovl = '0; m_route = '0; m_pend = '0; m_vsp = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            logic [NP-1:0] cp, rq;
            int a;
            a = int'(addr);
            for (int p = 0; p < NP; p++) begin
                cp[p] = m_pend[p] && vsync[p] && !m_vsp[p];
                rq[p] = wr_en && a == 0 && wdata[15] && wdata[p] && wdata[p+16];
            end
            for (int p = 0; p < NP; p++)
                if (cp[p] || m_sys[28]) m_pca[p] = m_pcs[p];
            for (int w = 0; w < NW; w++)
                if (cp[m_route[2*w +: 2]])
                    for (int f = 0; f < 4; f++) m_wa[w][f] = m_ws[w][f];
            if (cp[m_ovl[31:30]]) m_lsa = m_lss;
            for (int p = 0; p < NP; p++)
                m_pend[p] = rq[p] ? 1'b1 : (vsync[p] && !m_vsp[p]) ? 1'b0 : m_pend[p];
            if (wr_en) begin
                if (a == 1) m_sys = wdata;
                if (a == 2) m_ovl = wdata;
                if (a == 3) m_route = wdata[7:0];
                if (a == 4) m_lss = wdata;
                for (int p = 0; p < NP; p++) begin
                    if (a == 16 + p) m_pcs[p] = wdata;
                    if (a == 32 + p) m_aux[p] = wdata;
                end
                for (int w = 0; w < NW; w++)
                    for (int f = 0; f < 4; f++)
                        if (a == 64 + w*4 + f) m_ws[w][f] = wdata;
            end
            m_vsp = vsync;
        end
    end

    function automatic logic [DW-1:0] m_read(int a);
        if (a == 0) return DW'(m_pend);
        if (a == 1) return m_sys;
        if (a == 2) return m_ovl;
        if (a == 3) return DW'(m_route);
        if (a == 4) return m_lsa;
        for (int p = 0; p < NP; p++) begin
            if (a == 16 + p) return m_pca[p];
            if (a == 32 + p) return m_aux[p];
        end
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++)
                if (a == 64 + w*4 + f) return m_wa[w][f];
        return '0;
    endfunction

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, away from the edges
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R4", "pending", DW'(pending_o), DW'(m_pend));
            chk("R7", "layer_sel", layer_sel_o, m_lsa);
            chk("R8", "route", DW'(route_o), DW'(m_route));
            chk("R1", "readback", rdata, m_read(int'(addr)));
            for (int p = 0; p < NP; p++)
                chk("R5", "port_ctrl", port_ctrl_o[p*DW +: DW], m_pca[p]);
            for (int w = 0; w < NW; w++) begin
                chk("R6", "win_ctrl",   win_ctrl_o  [w*DW +: DW], m_wa[w][0]);
                chk("R6", "win_base",   win_base_o  [w*DW +: DW], m_wa[w][1]);
                chk("R6", "win_stride", win_stride_o[w*DW +: DW], m_wa[w][2]);
                chk("R6", "win_size",   win_size_o  [w*DW +: DW], m_wa[w][3]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(string req, int a, logic [DW-1:0] exp);
        @(negedge clk); wr_en = 0; addr = AW'(a);
        #1 chk(req, "directed read", rdata, exp);
    endtask

    task automatic vpulse(int p);
        @(negedge clk); vsync[p] = 1;
        @(negedge clk); vsync[p] = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 defaults
        rd("R10", 66, 32'h0000_0780);
        rd("R10", 67, 32'h0437_077F);
        rd("R10", 4, 32'h7654_3210);
        rd("R10", 0, 0);
        // R8 immediate registers; routing w0->2, w1->0, w2->1, w3->3
        wr(3, 32'hD2);
        rd("R8", 3, 32'hD2);
        wr(33, 32'hCAFE_0001);
        rd("R8", 33, 32'hCAFE_0001);
        // R1 / R9 staging, overwrite
        wr(65, 32'hA000_0000);
        rd("R1", 65, 0);
        wr(65, 32'hB000_0000);
        // R2 rejected commits
        wr(0, 32'h0004_0004);
        rd("R2", 0, 0);
        wr(0, 32'h0000_8004);
        rd("R2", 0, 0);
        // R4 accepted commit for port 2
        wr(0, 32'h0004_8004);
        rd("R4", 0, 32'h4);
        rd("R1", 65, 0);
        vpulse(2);
        rd("R4", 0, 0);
        rd("R9", 65, 32'hB000_0000);
        // R6 idle port: window 3 on port 3, vsync 3 never rises
        wr(76, 32'h1);
        wr(0, 32'h0008_8008);
        vpulse(0); vpulse(1); vpulse(2);
        rd("R6", 76, 0);
        rd("R6", 0, 32'h8);
        // R3 two ports in one write
        wr(16, 32'h1111);
        wr(18, 32'h2222);
        wr(0, 32'h0005_8005);
        rd("R3", 0, 32'hD);
        vpulse(0);
        rd("R3", 16, 32'h1111);
        rd("R3", 18, 0);
        rd("R3", 0, 32'hC);
        vpulse(2);
        rd("R3", 18, 32'h2222);
        // R11 vsync without pending
        wr(17, 32'h3333);
        vpulse(1);
        rd("R11", 17, 0);
        // R5 immediate latch: port regs follow, windows do not
        wr(1, 32'h1000_0000);
        rd("R5", 17, 32'h3333);
        wr(68, 32'h55);
        repeat (3) @(negedge clk);
        rd("R5", 68, 0);
        wr(1, 32'h0);
        // R7 layer-select source = port 2
        wr(2, 32'h8000_0000);
        wr(4, 32'h1234);
        wr(0, 32'h0001_8001);
        vpulse(0);
        rd("R7", 4, 32'h7654_3210);
        rd("R6", 68, 32'h55);
        wr(0, 32'h0004_8004);
        vpulse(2);
        rd("R7", 4, 32'h1234);
        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule